// File: doc/BRIEF.md
# Programmable-Frame Serial Transmitter

This block turns characters written by a host into asynchronous serial frames on a single output line. Each frame has a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and a high stop period that can last half a bit, one bit or two bits. Bit timing comes from an external 16x oversampling tick, so every full bit lasts sixteen ticks.

The host writes into a two-entry character buffer that sits in front of the shift register. Three outputs report status and can also serve as interrupt sources: a room flag that is high while another character may be written, a completion flag that is high once everything has left the line, and an enabled flag. One-cycle enable and disable strobes start and stop the transmitter. A disable waits for the frame in flight to finish and then empties the buffer. Frame settings are captured at the start of each frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `tx_out` is 1, `tx_enabled` is 0, `tx_done` is 0 and `buf_room` is 1.
- R2: A frame is a start bit at 0, the data bits least significant first, the parity bit if one is selected, then stop time at 1. Every full bit lasts 16 `baud_tick` pulses.
- R3: `cfg_len` holds the data bit count minus 3. Codes 2, 3, 4 and 5 send 5, 6, 7 and 8 bits. Data bits above the selected length are not sent.
- R4: `cfg_par` 00 sends no parity bit. 10 sends even parity, so the data bits plus the parity bit hold an even number of ones. 11 sends odd parity.
- R5: `cfg_stop` 00 gives 8 ticks of stop time, 01 gives 16 ticks and 11 gives 32 ticks. A frame therefore lasts 16*(1+bits+parity) ticks plus the stop time.
- R6: The buffer holds two characters. `buf_room` is 1 while fewer than two are held. A write while the buffer is full is dropped. Characters leave in the order they were written.
- R7: `tx_done` goes to 1 when the last stop period ends with the buffer empty, or when a disable takes effect. It goes to 0 on an accepted write.
- R8: A `cmd_en` pulse sets `tx_enabled` in the next cycle. Frames start only while the block is enabled. Characters written while disabled are held until it is enabled.
- R9: A `cmd_dis` pulse takes effect only once no frame is in flight. Until then `tx_enabled` stays 1. When it takes effect, `tx_enabled` goes to 0 and every buffered character is discarded.
- R10: If `cmd_en` and `cmd_dis` arrive in the same cycle, the disable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_len | input | 4 | Data bit count minus 3 |
| cfg_par | input | 2 | Parity select: 00 none, 10 even, 11 odd |
| cfg_stop | input | 2 | Stop select: 00 half, 01 one, 11 two bits |
| cmd_en | input | 1 | Enable strobe |
| cmd_dis | input | 1 | Disable strobe |
| wr_valid | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send |
| tx_out | output | 1 | Serial line, high when idle |
| buf_room | output | 1 | Buffer can take another character |
| tx_done | output | 1 | All characters have left the line |
| tx_enabled | output | 1 | Transmitter currently enabled |

## Verification
A host write and the shift register taking a character from the buffer can happen in the same cycle. The bench provokes this by writing three characters on consecutive cycles into an idle, enabled block, so the second write lands on the cycle the first character is loaded. It then checks that the room flag falls only after the third write, that a fourth write is lost, and that exactly three frames come out in write order. A second collision is an enable and a disable strobe in the same cycle. The bench checks that the block stays disabled and that a character written afterwards waits until a later enable.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_RSVD = 2'b01,
      PAR_EVEN = 2'b10,
      PAR_ODD  = 2'b11
   } par_mode_e;

   typedef enum logic [1:0] {
      STOP_HALF = 2'b00,
      STOP_ONE  = 2'b01,
      STOP_RSVD = 2'b10,
      STOP_TWO  = 2'b11
   } stop_mode_e;

   typedef enum logic [2:0] {
      SH_IDLE,
      SH_START,
      SH_DATA,
      SH_PAR,
      SH_STOP
   } sh_state_e;

endpackage

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] pop_data,
   output logic         not_empty,
   output logic         has_room
);
   localparam int FILL_W = $clog2(DEPTH + 1);

   logic [FILL_W-1:0] cnt;
   logic              do_push, do_pop;

   assign has_room  = (cnt != FILL_W'(DEPTH));
   assign not_empty = (cnt != '0);
   assign do_push   = push && has_room;
   assign do_pop    = pop && not_empty;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         cnt <= '0;
      end else begin
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] hold_q;
      always_ff @(posedge clk) begin
         if (do_push) hold_q <= push_data;
      end
      assign pop_data = hold_q;
   end else begin : g_ring
      localparam int PTR_W = $clog2(DEPTH);
      logic [W-1:0]     mem [DEPTH];
      logic [PTR_W-1:0] wr_p, rd_p;

      function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
         return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
      endfunction

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            wr_p <= '0;
            rd_p <= '0;
         end else begin
            if (do_push) wr_p <= step(wr_p);
            if (do_pop)  rd_p <= step(rd_p);
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) mem[wr_p] <= push_data;
      end

      assign pop_data = mem[rd_p];
   end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
   import uart_tx_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int LEN_W         = 4,
   parameter int LEN_BIAS      = 3,
   parameter int MIN_BITS      = 5,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [1:0]        cfg_par,
   input  logic [1:0]        cfg_stop,
   output logic              tx,
   output logic              busy,
   output logic              finish
);
   localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   sh_state_e         state;
   logic [DATA_W-1:0] shreg;
   logic [IDX_W-1:0]  idx_left;
   logic [CNT_W-1:0]  cnt, stop_last_q;
   logic              par_q, has_par_q;

   int                req_bits;
   logic [DATA_W-1:0] masked;
   logic              par_bit, has_par;
   logic [CNT_W-1:0]  stop_last;

   // settings captured at load time
   always_comb begin
      req_bits = int'(cfg_len) + LEN_BIAS;
      if (req_bits < MIN_BITS) req_bits = MIN_BITS;
      if (req_bits > DATA_W)   req_bits = DATA_W;
      for (int i = 0; i < DATA_W; i++) masked[i] = load_data[i] && (i < req_bits);
      has_par = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
      par_bit = (cfg_par == PAR_ODD) ? ~^masked : ^masked;
      case (cfg_stop)
         STOP_HALF: stop_last = CNT_W'(TICKS_PER_BIT / 2 - 1);
         STOP_TWO:  stop_last = CNT_W'(2 * TICKS_PER_BIT - 1);
         default:   stop_last = CNT_W'(TICKS_PER_BIT - 1);
      endcase
   end

   logic bit_end, stop_end, seg_end;
   assign bit_end  = tick && (cnt == CNT_W'(TICKS_PER_BIT - 1));
   assign stop_end = tick && (cnt == stop_last_q);
   assign seg_end  = (state == SH_STOP) ? stop_end : bit_end;
   assign finish   = (state == SH_STOP) && stop_end;
   assign busy     = (state != SH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= SH_IDLE;
         shreg       <= '0;
         idx_left    <= '0;
         cnt         <= '0;
         stop_last_q <= '0;
         par_q       <= 1'b0;
         has_par_q   <= 1'b0;
      end else if (load && !busy) begin
         state       <= SH_START;
         shreg       <= masked;
         idx_left    <= IDX_W'(req_bits - 1);
         cnt         <= '0;
         stop_last_q <= stop_last;
         par_q       <= par_bit;
         has_par_q   <= has_par;
      end else if (busy && tick) begin
         cnt <= seg_end ? '0 : cnt + 1'b1;
         if (seg_end) begin
            case (state)
               SH_START: state <= SH_DATA;
               SH_DATA: begin
                  shreg <= shreg >> 1;
                  if (idx_left == '0) state <= has_par_q ? SH_PAR : SH_STOP;
                  else                idx_left <= idx_left - 1'b1;
               end
               SH_PAR:  state <= SH_STOP;
               default: state <= SH_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (state)
         SH_START: tx = 1'b0;
         SH_DATA:  tx = shreg[0];
         SH_PAR:   tx = par_q;
         default:  tx = 1'b1;
      endcase
   end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_en,
   input  logic cmd_dis,
   input  logic busy,
   input  logic buf_nonempty,
   output logic enabled,
   output logic start,
   output logic flush
);
   logic dis_pend;

   // disable lands only between frames; it also drops the queue
   assign flush = (dis_pend || cmd_dis) && !busy;
   assign start = enabled && !dis_pend && !cmd_dis && !busy && buf_nonempty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enabled  <= 1'b0;
         dis_pend <= 1'b0;
      end else if (flush) begin
         enabled  <= 1'b0;
         dis_pend <= 1'b0;
      end else if (cmd_dis) begin
         dis_pend <= 1'b1;
      end else if (cmd_en) begin
         enabled  <= 1'b1;
         dis_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
   parameter int DATA_W        = 8,
   parameter int LEN_W         = 4,
   parameter int LEN_BIAS      = 3,
   parameter int MIN_BITS      = 5,
   parameter int BUF_DEPTH     = 2,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [1:0]        cfg_par,
   input  logic [1:0]        cfg_stop,
   input  logic              cmd_en,
   input  logic              cmd_dis,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tx_out,
   output logic              buf_room,
   output logic              tx_done,
   output logic              tx_enabled
);
   if (BUF_DEPTH < 1) begin : g_bad_depth
      $error("BUF_DEPTH must be at least 1");
   end
   if (TICKS_PER_BIT < 2 || (TICKS_PER_BIT % 2) != 0) begin : g_bad_ticks
      $error("TICKS_PER_BIT must be even and at least 2");
   end
   if (DATA_W < MIN_BITS) begin : g_bad_width
      $error("DATA_W must not be below MIN_BITS");
   end

   logic              shf_busy, shf_finish, start, flush;
   logic              buf_nonempty, wr_acc;
   logic [DATA_W-1:0] head_data;
   logic              done_q;

   assign wr_acc = wr_valid && buf_room && !flush;

   uart_tx_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_en       (cmd_en),
      .cmd_dis      (cmd_dis),
      .busy         (shf_busy),
      .buf_nonempty (buf_nonempty),
      .enabled      (tx_enabled),
      .start        (start),
      .flush        (flush)
   );

   uart_tx_buf #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (wr_acc),
      .push_data (wr_data),
      .pop       (start),
      .pop_data  (head_data),
      .not_empty (buf_nonempty),
      .has_room  (buf_room)
   );

   uart_tx_shift #(
      .DATA_W        (DATA_W),
      .LEN_W         (LEN_W),
      .LEN_BIAS      (LEN_BIAS),
      .MIN_BITS      (MIN_BITS),
      .TICKS_PER_BIT (TICKS_PER_BIT)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .load      (start),
      .load_data (head_data),
      .cfg_len   (cfg_len),
      .cfg_par   (cfg_par),
      .cfg_stop  (cfg_stop),
      .tx        (tx_out),
      .busy      (shf_busy),
      .finish    (shf_finish)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                           done_q <= 1'b0;
      else if (flush)                       done_q <= 1'b1;
      else if (wr_acc)                      done_q <= 1'b0;
      else if (shf_finish && !buf_nonempty) done_q <= 1'b1;
   end
   assign tx_done = done_q;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_out,
   input logic tx_enabled,
   input logic tx_done,
   input logic buf_room,
   input logic cmd_en,
   input logic cmd_dis,
   input logic busy,
   input logic load,
   input logic flush,
   input logic nonempty
);
   // R9
   off_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_enabled |-> tx_out);

   // R9
   hold_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && tx_enabled |=> tx_enabled);

   // R10
   both_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_en && cmd_dis && !busy |=> !tx_enabled);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> !busy && !nonempty);

   // R6
   room_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_room) |-> $past(load || flush));

   // R8
   load_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> tx_enabled && !busy);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_out     (tx_out),
   .tx_enabled (tx_enabled),
   .tx_done    (tx_done),
   .buf_room   (buf_room),
   .cmd_en     (cmd_en),
   .cmd_dis    (cmd_dis),
   .busy       (shf_busy),
   .load       (start),
   .flush      (flush),
   .nonempty   (buf_nonempty)
);

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic [3:0] cfg_len = 4'd5;
   logic [1:0] cfg_par = 2'b00;
   logic [1:0] cfg_stop = 2'b01;
   logic       cmd_en = 1'b0, cmd_dis = 1'b0, wr_valid = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       tx_out, buf_room, tx_done, tx_enabled;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   uart_frame_tx u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
      .cmd_en(cmd_en), .cmd_dis(cmd_dis),
      .wr_valid(wr_valid), .wr_data(wr_data),
      .tx_out(tx_out), .buf_room(buf_room), .tx_done(tx_done), .tx_enabled(tx_enabled)
   );

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_byte(input logic [7:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse(input bit en, input bit dis);
      @(negedge clk);
      cmd_en  = en;
      cmd_dis = dis;
      @(negedge clk);
      cmd_en  = 1'b0;
      cmd_dis = 1'b0;
   endtask

   // decode one frame from the line, optionally count ticks until tx_done rises
   task automatic rx_frame(input int nb, input bit hp, input bit meas,
                           output logic [7:0] d, output logic pb,
                           output logic sb, output int tk);
      int t = 0;
      int guard = 0;
      int last_s;
      d = '0; pb = 1'b0; sb = 1'b0; tk = -1;
      while (tx_out !== 1'b0 && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      last_s = 8 + 16 * (1 + nb + (hp ? 1 : 0));
      while (guard < 40000) begin
         @(posedge clk);
         #1;
         guard++;
         if (baud_tick) begin
            t++;
            if (t >= 24 && ((t - 8) % 16) == 0) begin
               int k = (t - 8) / 16;
               if (k >= 1 && k <= nb)      d[k-1] = tx_out;
               else if (hp && k == nb + 1) pb = tx_out;
            end
            if (t == last_s) sb = tx_out;
         end
         if (meas && tx_done) begin
            tk = t;
            break;
         end
         if (!meas && t == last_s) break;
      end
   endtask

   task automatic watch_high(input int nticks, output int lows);
      int t = 0;
      lows = 0;
      while (t < nticks) begin
         @(posedge clk);
         #1;
         if (tx_out !== 1'b1) lows++;
         if (baud_tick) t++;
      end
   endtask

   function automatic logic exp_par(input logic [7:0] d, input int nb, input logic [1:0] mode);
      logic [7:0] m = d & 8'((1 << nb) - 1);
      return (mode == 2'b11) ? ~^m : ^m;
   endfunction

   task automatic t_reset;
      check("R1 tx idle", tx_out, 1);
      check("R1 enabled", tx_enabled, 0);
      check("R1 done", tx_done, 0);
      check("R1 room", buf_room, 1);
   endtask

   task automatic t_enable;
      pulse(1'b1, 1'b0);
      check("R8 enabled after cmd_en", tx_enabled, 1);
   endtask

   task automatic t_frame(input logic [3:0] code, input logic [1:0] par,
                          input logic [1:0] stp, input logic [7:0] data);
      int nb = int'(code) + 3;
      bit hp = par[1];
      int stop_t = (stp == 2'b00) ? 8 : (stp == 2'b11) ? 32 : 16;
      logic [7:0] d; logic pb, sb; int tk;
      cfg_len = code; cfg_par = par; cfg_stop = stp;
      write_byte(data);
      check("R7 done cleared by write", tx_done, 0);
      rx_frame(nb, hp, 1'b1, d, pb, sb, tk);
      check("R3 data bits", d, data & 8'((1 << nb) - 1));
      if (hp) check("R4 parity bit", pb, exp_par(data, nb, par));
      check("R2 stop level", sb, 1);
      check("R5 frame ticks", tk, 16 * (1 + nb + (hp ? 1 : 0)) + stop_t);
      check("R7 done after frame", tx_done, 1);
   endtask

   task automatic t_buffer;
      logic [7:0] d1, d2, d3; logic pb, sb; int tk, lows;
      cfg_len = 4'd5; cfg_par = 2'b00; cfg_stop = 2'b01;
      fork
         begin
            rx_frame(8, 1'b0, 1'b0, d1, pb, sb, tk);
            rx_frame(8, 1'b0, 1'b0, d2, pb, sb, tk);
            rx_frame(8, 1'b0, 1'b1, d3, pb, sb, tk);
         end
         begin
            @(negedge clk); wr_valid = 1'b1; wr_data = 8'h11;
            @(negedge clk); wr_data = 8'h22;
            @(negedge clk); wr_data = 8'h33;
            @(negedge clk); wr_valid = 1'b0;
            check("R6 room low with two held", buf_room, 0);
            write_byte(8'h44);
            check("R6 room still low after dropped write", buf_room, 0);
         end
      join
      check("R6 order first", d1, 8'h11);
      check("R6 order second", d2, 8'h22);
      check("R6 order third", d3, 8'h33);
      check("R7 done after queue drains", tx_done, 1);
      watch_high(50, lows);
      check("R6 dropped write never sent", lows, 0);
      check("R6 room restored", buf_room, 1);
   endtask

   task automatic t_disable;
      logic [7:0] d; logic pb, sb; int tk, lows;
      fork
         rx_frame(8, 1'b0, 1'b1, d, pb, sb, tk);
         begin
            write_byte(8'h5A);
            write_byte(8'h66);
            repeat (160) @(negedge clk);
            pulse(1'b0, 1'b1);
            check("R9 enabled held during frame", tx_enabled, 1);
         end
      join
      check("R9 frame in flight completes", d, 8'h5A);
      check("R9 frame length intact", tk, 160);
      check("R9 disabled after frame", tx_enabled, 0);
      check("R9 buffer emptied", buf_room, 1);
      watch_high(200, lows);
      check("R9 buffered char discarded", lows, 0);
      pulse(1'b1, 1'b0);
      watch_high(100, lows);
      check("R9 nothing left after re-enable", lows, 0);
      check("R8 enabled again", tx_enabled, 1);
   endtask

   task automatic t_both;
      logic [7:0] d; logic pb, sb; int tk, lows;
      pulse(1'b1, 1'b1);
      check("R10 disable wins", tx_enabled, 0);
      write_byte(8'h3C);
      check("R7 done cleared while disabled", tx_done, 0);
      watch_high(100, lows);
      check("R8 no frame while disabled", lows, 0);
      fork
         rx_frame(8, 1'b0, 1'b1, d, pb, sb, tk);
         pulse(1'b1, 1'b0);
      join
      check("R8 held char sent after enable", d, 8'h3C);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_frame(4'd5, 2'b00, 2'b01, 8'hA5);
      t_frame(4'd2, 2'b10, 2'b01, 8'hF3);
      t_frame(4'd4, 2'b11, 2'b01, 8'h4E);
      t_frame(4'd3, 2'b00, 2'b11, 8'h2D);
      t_frame(4'd5, 2'b00, 2'b00, 8'h81);
      t_frame(4'd5, 2'b11, 2'b11, 8'h00);
      t_buffer();
      t_disable();
      t_both();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule